// File: doc/BRIEF.md
# Load/Store Memory Ordering Buffer

This block sits between the out-of-order scheduler and the data memory pipeline and decides, cycle by cycle, which memory micro-op may be sent to memory next. A load is one micro-op that carries its address when it is allocated. A store is allocated first and then receives its address and its data as two independent micro-ops, matched to it by age tag. A store also needs a separate commit notice before it may leave, because a store that has been sent cannot be taken back.

Stores leave strictly in allocation order and only once they are complete and committed. Loads are picked oldest-first among those that are free to go, so a load may overtake older loads and older stores. The exception is an older store whose address is still unknown or equal to the load's address: such a load waits in its entry and is picked again as soon as that store has left. A single shared request port carries one operation per clock, and a level input holds all issue while memory cannot take requests. A flush removes all work younger than a given age tag, with committed stores kept.

Top module: `mem_order_buf`

## Requirements
- R1: While and after reset, with nothing allocated, `req_valid`, `ld_full` and `st_full` are all 0.
- R2: A store is requested (`req_valid`=1, `req_is_store`=1, with its own address, data and age) only once its address, its data and its commit notice have all arrived; any two of the three are not enough.
- R3: Stores are requested in the order they were allocated; a complete, committed store waits while any older store is still held.
- R4: Age tags are `AGE_W` bits wide and wrap; tag a is older than tag b when (a - b) modulo 2^AGE_W has its top bit set. Entries must be allocated in age order.
- R5: A load with no older held store of unknown or equal address is requested (`req_is_store`=0, its address and age) in the first cycle after its allocation edge, even if older stores with other addresses are held.
- R6: A load is held while an older store in the buffer has no address yet or has the load's address, and is requested once that store has left.
- R7: Among loads free to go, the oldest is requested first; a held older load does not stop a younger free load.
- R8: At most one request per cycle; when a store and a load are both ready, the store is requested and the load waits.
- R9: While `mem_block` is 1 no request is made; held operations are requested once it returns to 0.
- R10: A flush drops every load and every uncommitted store younger than `flush_age`; committed stores are kept, and nothing is requested in the flush cycle.
- R11: `ld_full` / `st_full` are 1 when all `LQ_DEPTH` / `SQ_DEPTH` entries are in use; an allocation while full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_alloc_valid | input | 1 | Allocate a load this cycle |
| ld_alloc_age | input | AGE_W | Age tag of the new load |
| ld_alloc_addr | input | ADDR_W | Address of the new load |
| st_alloc_valid | input | 1 | Allocate a store this cycle |
| st_alloc_age | input | AGE_W | Age tag of the new store |
| sta_valid | input | 1 | Store-address micro-op arrives |
| sta_age | input | AGE_W | Age tag of the store it belongs to |
| sta_addr | input | ADDR_W | Store address |
| std_valid | input | 1 | Store-data micro-op arrives |
| std_age | input | AGE_W | Age tag of the store it belongs to |
| std_data | input | DATA_W | Store data |
| commit_valid | input | 1 | Store becomes non-speculative |
| commit_age | input | AGE_W | Age tag of the committed store |
| flush_valid | input | 1 | Flush younger work this cycle |
| flush_age | input | AGE_W | Entries younger than this tag are dropped |
| mem_block | input | 1 | Memory cannot accept a request this cycle |
| req_valid | output | 1 | Request to memory this cycle |
| req_is_store | output | 1 | 1 = store request, 0 = load request |
| req_age | output | AGE_W | Age tag of the requested operation |
| req_addr | output | ADDR_W | Request address |
| req_data | output | DATA_W | Store data (0 for loads) |
| ld_full | output | 1 | All load entries in use |
| st_full | output | 1 | All store entries in use |

## Verification
Stores are built up with their three parts arriving in different orders, which separates a design that waits for all three from one that fires on address and data alone, and a younger store completed before an older one shows whether allocation order is kept. Loads are placed behind stores with a different address, an equal address and no address yet, telling an address-aware hold from a blanket or missing one, and a held older load beside a free younger one shows whether loads really overtake each other. Contention with `mem_block` raised and then lowered exposes the store-first choice and the oldest-first load order, and a flush with a committed store younger than the flush tag separates "drop uncommitted" from "drop everything younger". Filling both queues and allocating once more shows that the extra entry is dropped rather than overwriting one.

// File: rtl/mob_pkg.sv
package mob_pkg;

  typedef enum logic [1:0] {
    GNT_NONE  = 2'd0,
    GNT_LOAD  = 2'd1,
    GNT_STORE = 2'd2
  } grant_e;

  // a older than b when (a - b) mod 2^w has its top bit set
  function automatic logic age_older(input logic [31:0] a, input logic [31:0] b,
                                     input int unsigned w);
    logic [31:0] diff;
    logic [31:0] top;
    diff = a - b;
    top  = diff >> (w - 1);
    return top[0];
  endfunction

  // store first, nothing while held
  function automatic grant_e pick_grant(input logic st_rdy, input logic ld_rdy,
                                        input logic hold);
    if (hold)        return GNT_NONE;
    else if (st_rdy) return GNT_STORE;
    else if (ld_rdy) return GNT_LOAD;
    else             return GNT_NONE;
  endfunction

endpackage

// File: rtl/mob_store_queue.sv
module mob_store_queue
  import mob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int AGE_W  = 6,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [AGE_W-1:0]  alloc_age,
  input  logic              sta_valid,
  input  logic [AGE_W-1:0]  sta_age,
  input  logic [ADDR_W-1:0] sta_addr,
  input  logic              std_valid,
  input  logic [AGE_W-1:0]  std_age,
  input  logic [DATA_W-1:0] std_data,
  input  logic              commit_valid,
  input  logic [AGE_W-1:0]  commit_age,
  input  logic              flush_valid,
  input  logic [AGE_W-1:0]  flush_age,
  input  logic              issue,
  output logic              head_valid,
  output logic              head_ready,
  output logic [AGE_W-1:0]  head_age,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data,
  output logic              full,
  output logic [DEPTH-1:0]  e_valid,
  output logic [AGE_W-1:0]  e_age [DEPTH],
  output logic [DEPTH-1:0]  e_addr_ok,
  output logic [ADDR_W-1:0] e_addr [DEPTH]
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = IDX_W + 1;

  logic [DEPTH-1:0]  v, aok, dok, cmt;
  logic [AGE_W-1:0]  age  [DEPTH];
  logic [ADDR_W-1:0] addr [DEPTH];
  logic [DATA_W-1:0] data [DEPTH];
  logic [IDX_W-1:0]  head, tail;
  logic [CNT_W-1:0]  cnt;

  logic [DEPTH-1:0]  drop;
  logic [CNT_W-1:0]  keep_n;
  logic              do_alloc;

  // entries a flush would remove; they form the tail end of the ring
  always_comb begin
    keep_n = '0;
    for (int i = 0; i < DEPTH; i++) begin
      drop[i] = v[i] && !cmt[i] && age_older(32'(flush_age), 32'(age[i]), AGE_W);
      if (v[i] && !drop[i]) keep_n = keep_n + CNT_W'(1);
    end
  end

  assign full     = (cnt == CNT_W'(DEPTH));
  assign do_alloc = alloc_valid && !full && !flush_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v    <= '0;
      aok  <= '0;
      dok  <= '0;
      cmt  <= '0;
      head <= '0;
      tail <= '0;
      cnt  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        age[i]  <= '0;
        addr[i] <= '0;
        data[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (v[i] && sta_valid && age[i] == sta_age) begin
          aok[i]  <= 1'b1;
          addr[i] <= sta_addr;
        end
        if (v[i] && std_valid && age[i] == std_age) begin
          dok[i]  <= 1'b1;
          data[i] <= std_data;
        end
        if (v[i] && commit_valid && age[i] == commit_age) cmt[i] <= 1'b1;
      end
      if (issue) begin
        v[head] <= 1'b0;
        head    <= head + IDX_W'(1);
      end
      if (flush_valid) begin
        for (int i = 0; i < DEPTH; i++)
          if (drop[i]) v[i] <= 1'b0;
        tail <= head + keep_n[IDX_W-1:0];
        cnt  <= keep_n;
      end else begin
        if (do_alloc) begin
          v[tail]   <= 1'b1;
          aok[tail] <= 1'b0;
          dok[tail] <= 1'b0;
          cmt[tail] <= 1'b0;
          age[tail] <= alloc_age;
          tail      <= tail + IDX_W'(1);
        end
        cnt <= cnt + CNT_W'(do_alloc) - CNT_W'(issue);
      end
    end
  end

  assign head_valid = v[head];
  assign head_ready = v[head] && aok[head] && dok[head] && cmt[head];
  assign head_age   = age[head];
  assign head_addr  = addr[head];
  assign head_data  = data[head];
  assign e_valid    = v;
  assign e_addr_ok  = aok;

  for (genvar g = 0; g < DEPTH; g++) begin : g_view
    assign e_age[g]  = age[g];
    assign e_addr[g] = addr[g];
  end

endmodule

// File: rtl/mob_load_queue.sv
module mob_load_queue
  import mob_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int SQ_DEPTH = 8,
  parameter int AGE_W    = 6,
  parameter int ADDR_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [AGE_W-1:0]  alloc_age,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              flush_valid,
  input  logic [AGE_W-1:0]  flush_age,
  input  logic              issue,
  input  logic [SQ_DEPTH-1:0] sq_valid,
  input  logic [AGE_W-1:0]  sq_age [SQ_DEPTH],
  input  logic [SQ_DEPTH-1:0] sq_addr_ok,
  input  logic [ADDR_W-1:0] sq_addr [SQ_DEPTH],
  output logic              sel_valid,
  output logic [AGE_W-1:0]  sel_age,
  output logic [ADDR_W-1:0] sel_addr,
  output logic              full
);

  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0]  v;
  logic [AGE_W-1:0]  age  [DEPTH];
  logic [ADDR_W-1:0] addr [DEPTH];

  logic [DEPTH-1:0]  blocked;
  logic [DEPTH-1:0]  elig;
  logic              free_found;
  logic [IDX_W-1:0]  free_idx;
  logic [IDX_W-1:0]  sel_idx;

  // per-entry hold: an older store with no address or the same address
  for (genvar g = 0; g < DEPTH; g++) begin : g_blk
    always_comb begin
      blocked[g] = 1'b0;
      for (int s = 0; s < SQ_DEPTH; s++)
        if (sq_valid[s] && age_older(32'(sq_age[s]), 32'(age[g]), AGE_W) &&
            (!sq_addr_ok[s] || sq_addr[s] == addr[g]))
          blocked[g] = 1'b1;
    end
  end

  assign elig = v & ~blocked;
  assign full = &v;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!v[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
  end

  // oldest free load wins
  always_comb begin
    sel_valid = 1'b0;
    sel_idx   = '0;
    for (int i = 0; i < DEPTH; i++)
      if (elig[i] && (!sel_valid ||
                      age_older(32'(age[i]), 32'(age[sel_idx]), AGE_W))) begin
        sel_valid = 1'b1;
        sel_idx   = IDX_W'(i);
      end
  end

  assign sel_age  = age[sel_idx];
  assign sel_addr = addr[sel_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        age[i]  <= '0;
        addr[i] <= '0;
      end
    end else begin
      if (issue) v[sel_idx] <= 1'b0;
      if (flush_valid) begin
        for (int i = 0; i < DEPTH; i++)
          if (v[i] && age_older(32'(flush_age), 32'(age[i]), AGE_W)) v[i] <= 1'b0;
      end else if (alloc_valid && free_found) begin
        v[free_idx]    <= 1'b1;
        age[free_idx]  <= alloc_age;
        addr[free_idx] <= alloc_addr;
      end
    end
  end

endmodule

// File: rtl/mob_issue_arb.sv
module mob_issue_arb
  import mob_pkg::*;
#(
  parameter int AGE_W  = 6,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              st_ready,
  input  logic [AGE_W-1:0]  st_age,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic              ld_ready,
  input  logic [AGE_W-1:0]  ld_age,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              hold,
  output logic              st_issue,
  output logic              ld_issue,
  output logic              req_valid,
  output logic              req_is_store,
  output logic [AGE_W-1:0]  req_age,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data
);

  grant_e gnt;

  assign gnt          = pick_grant(st_ready, ld_ready, hold);
  assign st_issue     = (gnt == GNT_STORE);
  assign ld_issue     = (gnt == GNT_LOAD);
  assign req_valid    = st_issue || ld_issue;
  assign req_is_store = st_issue;
  assign req_age      = st_issue ? st_age  : ld_age;
  assign req_addr     = st_issue ? st_addr : ld_addr;
  assign req_data     = st_issue ? st_data : '0;

endmodule

// File: rtl/mem_order_buf.sv
module mem_order_buf
  import mob_pkg::*;
#(
  parameter int LQ_DEPTH = 8,
  parameter int SQ_DEPTH = 8,
  parameter int AGE_W    = 6,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_alloc_valid,
  input  logic [AGE_W-1:0]  ld_alloc_age,
  input  logic [ADDR_W-1:0] ld_alloc_addr,
  input  logic              st_alloc_valid,
  input  logic [AGE_W-1:0]  st_alloc_age,
  input  logic              sta_valid,
  input  logic [AGE_W-1:0]  sta_age,
  input  logic [ADDR_W-1:0] sta_addr,
  input  logic              std_valid,
  input  logic [AGE_W-1:0]  std_age,
  input  logic [DATA_W-1:0] std_data,
  input  logic              commit_valid,
  input  logic [AGE_W-1:0]  commit_age,
  input  logic              flush_valid,
  input  logic [AGE_W-1:0]  flush_age,
  input  logic              mem_block,
  output logic              req_valid,
  output logic              req_is_store,
  output logic [AGE_W-1:0]  req_age,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic              ld_full,
  output logic              st_full
);

  // named internal events, used by the checker
  logic              st_issue, ld_issue;
  logic              sq_head_valid, sq_head_ready;
  logic [AGE_W-1:0]  sq_head_age;
  logic [ADDR_W-1:0] sq_head_addr;
  logic [DATA_W-1:0] sq_head_data;
  logic [SQ_DEPTH-1:0] sq_valid, sq_addr_ok;
  logic [AGE_W-1:0]  sq_age  [SQ_DEPTH];
  logic [ADDR_W-1:0] sq_addr [SQ_DEPTH];
  logic              lq_sel_valid;
  logic [AGE_W-1:0]  lq_sel_age;
  logic [ADDR_W-1:0] lq_sel_addr;

  mob_store_queue #(
    .DEPTH(SQ_DEPTH), .AGE_W(AGE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_sq (
    .clk, .rst_n,
    .alloc_valid (st_alloc_valid), .alloc_age (st_alloc_age),
    .sta_valid, .sta_age, .sta_addr,
    .std_valid, .std_age, .std_data,
    .commit_valid, .commit_age,
    .flush_valid, .flush_age,
    .issue       (st_issue),
    .head_valid  (sq_head_valid),
    .head_ready  (sq_head_ready),
    .head_age    (sq_head_age),
    .head_addr   (sq_head_addr),
    .head_data   (sq_head_data),
    .full        (st_full),
    .e_valid     (sq_valid),
    .e_age       (sq_age),
    .e_addr_ok   (sq_addr_ok),
    .e_addr      (sq_addr)
  );

  mob_load_queue #(
    .DEPTH(LQ_DEPTH), .SQ_DEPTH(SQ_DEPTH), .AGE_W(AGE_W), .ADDR_W(ADDR_W)
  ) u_lq (
    .clk, .rst_n,
    .alloc_valid (ld_alloc_valid), .alloc_age (ld_alloc_age), .alloc_addr (ld_alloc_addr),
    .flush_valid, .flush_age,
    .issue       (ld_issue),
    .sq_valid, .sq_age, .sq_addr_ok, .sq_addr,
    .sel_valid   (lq_sel_valid),
    .sel_age     (lq_sel_age),
    .sel_addr    (lq_sel_addr),
    .full        (ld_full)
  );

  mob_issue_arb #(
    .AGE_W(AGE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_arb (
    .st_ready (sq_head_ready), .st_age (sq_head_age),
    .st_addr  (sq_head_addr),  .st_data (sq_head_data),
    .ld_ready (lq_sel_valid),  .ld_age (lq_sel_age), .ld_addr (lq_sel_addr),
    .hold     (mem_block || flush_valid),
    .st_issue, .ld_issue,
    .req_valid, .req_is_store, .req_age, .req_addr, .req_data
  );

endmodule

// File: rtl/mob_checker.sv
module mob_checker
  import mob_pkg::*;
#(
  parameter int SQ_DEPTH = 8,
  parameter int AGE_W    = 6,
  parameter int ADDR_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_block,
  input logic              flush_valid,
  input logic              req_valid,
  input logic              req_is_store,
  input logic [AGE_W-1:0]  req_age,
  input logic [ADDR_W-1:0] req_addr,
  input logic              st_issue,
  input logic              ld_issue,
  input logic              sq_head_valid,
  input logic              sq_head_ready,
  input logic [AGE_W-1:0]  sq_head_age,
  input logic [SQ_DEPTH-1:0] sq_valid,
  input logic [AGE_W-1:0]  sq_age [SQ_DEPTH],
  input logic [SQ_DEPTH-1:0] sq_addr_ok,
  input logic [ADDR_W-1:0] sq_addr [SQ_DEPTH]
);

  logic ld_conflict;

  always_comb begin
    ld_conflict = 1'b0;
    for (int s = 0; s < SQ_DEPTH; s++)
      if (sq_valid[s] && age_older(32'(sq_age[s]), 32'(req_age), AGE_W) &&
          (!sq_addr_ok[s] || sq_addr[s] == req_addr))
        ld_conflict = 1'b1;
  end

  always @(posedge clk) begin
    if (!rst_n) p_reset_idle_r1: assert (!req_valid);
  end

  p_store_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st_issue |=> (!sq_head_valid ||
                  age_older(32'($past(req_age)), 32'(sq_head_age), AGE_W)));

  p_load_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_issue |-> !ld_conflict);

  p_single_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_issue, ld_issue}));

  p_store_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_issue |-> !sq_head_ready);

  p_store_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_issue |-> (req_valid && req_is_store && sq_head_valid));

  p_block_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_block |-> !req_valid);

  p_flush_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> !req_valid);

endmodule

bind mem_order_buf mob_checker #(
  .SQ_DEPTH(SQ_DEPTH), .AGE_W(AGE_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk (clk), .rst_n (rst_n), .mem_block (mem_block), .flush_valid (flush_valid),
  .req_valid (req_valid), .req_is_store (req_is_store), .req_age (req_age),
  .req_addr (req_addr), .st_issue (st_issue), .ld_issue (ld_issue),
  .sq_head_valid (sq_head_valid), .sq_head_ready (sq_head_ready),
  .sq_head_age (sq_head_age), .sq_valid (sq_valid), .sq_age (sq_age),
  .sq_addr_ok (sq_addr_ok), .sq_addr (sq_addr)
);

// File: tb/tb_mem_order_buf.sv
`timescale 1ns/1ps
module tb_mem_order_buf;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_alloc_valid = 0; logic [5:0] ld_alloc_age = 0; logic [15:0] ld_alloc_addr = 0;
  logic        st_alloc_valid = 0; logic [5:0] st_alloc_age = 0;
  logic        sta_valid = 0;      logic [5:0] sta_age = 0;      logic [15:0] sta_addr = 0;
  logic        std_valid = 0;      logic [5:0] std_age = 0;      logic [31:0] std_data = 0;
  logic        commit_valid = 0;   logic [5:0] commit_age = 0;
  logic        flush_valid = 0;    logic [5:0] flush_age = 0;
  logic        mem_block = 0;
  logic        req_valid, req_is_store, ld_full, st_full;
  logic [5:0]  req_age;
  logic [15:0] req_addr;
  logic [31:0] req_data;

  int vectors = 0;
  int errors  = 0;

  always #2.5 clk = ~clk;

  mem_order_buf dut (.*);

  task automatic tick();
    @(posedge clk); #1;
    ld_alloc_valid = 0; st_alloc_valid = 0; sta_valid = 0;
    std_valid = 0; commit_valid = 0; flush_valid = 0;
    #1;
  endtask

  task automatic do_ld(input logic [5:0] a, input logic [15:0] ad);
    ld_alloc_valid = 1; ld_alloc_age = a; ld_alloc_addr = ad; tick();
  endtask
  task automatic do_st(input logic [5:0] a);
    st_alloc_valid = 1; st_alloc_age = a; tick();
  endtask
  task automatic do_sta(input logic [5:0] a, input logic [15:0] ad);
    sta_valid = 1; sta_age = a; sta_addr = ad; tick();
  endtask
  task automatic do_std(input logic [5:0] a, input logic [31:0] d);
    std_valid = 1; std_age = a; std_data = d; tick();
  endtask
  task automatic do_cmt(input logic [5:0] a);
    commit_valid = 1; commit_age = a; tick();
  endtask
  task automatic do_flush(input logic [5:0] a);
    flush_valid = 1; flush_age = a; tick();
  endtask
  task automatic set_block(input logic b);
    mem_block = b; #1;
  endtask

  task automatic expect_req(input string tag, input logic ev, input logic es,
                            input logic [5:0] ea, input logic [15:0] ead, input logic [31:0] ed);
    vectors++;
    if (req_valid !== ev ||
        (ev && (req_is_store !== es || req_age !== ea || req_addr !== ead ||
                (es && req_data !== ed)))) begin
      errors++;
      $display("FAIL %s: got v=%0b st=%0b age=%0d addr=%h data=%h, expected v=%0b st=%0b age=%0d addr=%h data=%h",
               tag, req_valid, req_is_store, req_age, req_addr, req_data, ev, es, ea, ead, ed);
    end
  endtask

  task automatic expect_none(input string tag);
    expect_req(tag, 1'b0, 1'b0, 6'd0, 16'h0, 32'h0);
  endtask

  task automatic expect_flag(input string tag, input logic got, input logic exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b, expected %0b", tag, got, exp);
    end
  endtask

  task automatic t_reset();
    expect_none("R1 idle after reset");
    expect_flag("R1 ld_full after reset", ld_full, 1'b0);
    expect_flag("R1 st_full after reset", st_full, 1'b0);
  endtask

  task automatic t_store_combine();
    do_st(6'd1); do_sta(6'd1, 16'h0010); do_cmt(6'd1);
    expect_none("R2 address and commit without data");
    do_std(6'd1, 32'hA5A5_0001);
    expect_req("R2 complete store", 1, 1, 6'd1, 16'h0010, 32'hA5A5_0001);
    tick();
    expect_none("R2 store leaves once");
    do_st(6'd2); do_sta(6'd2, 16'h0014); do_std(6'd2, 32'h0000_00B2);
    expect_none("R2 speculative store held");
    do_cmt(6'd2);
    expect_req("R2 store after commit", 1, 1, 6'd2, 16'h0014, 32'h0000_00B2);
    tick();
  endtask

  task automatic t_store_order();
    do_st(6'd3); do_st(6'd4);
    do_sta(6'd4, 16'h0018); do_std(6'd4, 32'h44); do_cmt(6'd4);
    expect_none("R3 younger store waits for older");
    do_sta(6'd3, 16'h001C); do_std(6'd3, 32'h33); do_cmt(6'd3);
    expect_req("R3 older store first", 1, 1, 6'd3, 16'h001C, 32'h33);
    tick();
    expect_req("R3 younger store second", 1, 1, 6'd4, 16'h0018, 32'h44);
    tick();
    expect_none("R3 store queue drained");
  endtask

  task automatic t_load_bypass();
    do_st(6'd5); do_sta(6'd5, 16'h0020);
    do_ld(6'd6, 16'h0030);
    expect_req("R5 R4 load passes store to other address", 1, 0, 6'd6, 16'h0030, 32'h0);
    tick();
    do_ld(6'd7, 16'h0020);
    expect_none("R6 load held behind same-address store");
    do_st(6'd8);
    do_ld(6'd9, 16'h0040);
    expect_none("R6 load held behind store with no address");
    do_sta(6'd8, 16'h0050);
    expect_req("R7 younger free load passes held older load", 1, 0, 6'd9, 16'h0040, 32'h0);
    tick();
    expect_none("R6 same-address load still held");
    do_std(6'd5, 32'h55); do_cmt(6'd5);
    expect_req("R2 blocking store leaves", 1, 1, 6'd5, 16'h0020, 32'h55);
    tick();
    expect_req("R6 held load redispatched", 1, 0, 6'd7, 16'h0020, 32'h0);
    tick();
    expect_none("R6 load queue drained");
  endtask

  task automatic t_priority();
    set_block(1);
    do_std(6'd8, 32'h88); do_cmt(6'd8);
    do_ld(6'd10, 16'h0060); do_ld(6'd11, 16'h0070); do_ld(6'd12, 16'h0074);
    expect_none("R9 nothing while memory blocked");
    set_block(0);
    expect_req("R8 store wins over ready load", 1, 1, 6'd8, 16'h0050, 32'h88);
    tick();
    expect_req("R7 oldest load first", 1, 0, 6'd10, 16'h0060, 32'h0);
    tick();
    expect_req("R7 next oldest load", 1, 0, 6'd11, 16'h0070, 32'h0);
    tick();
    expect_req("R9 last held load", 1, 0, 6'd12, 16'h0074, 32'h0);
    tick();
    expect_none("R9 all drained");
  endtask

  task automatic t_flush();
    set_block(1);
    do_st(6'd13); do_sta(6'd13, 16'h0090); do_std(6'd13, 32'hD13); do_cmt(6'd13);
    do_st(6'd14); do_sta(6'd14, 16'h0094);
    do_ld(6'd15, 16'h0098);
    do_flush(6'd12);
    set_block(0);
    expect_req("R10 committed store survives flush", 1, 1, 6'd13, 16'h0090, 32'hD13);
    tick();
    expect_none("R10 younger load flushed");
    do_std(6'd14, 32'hE14); do_cmt(6'd14);
    expect_none("R10 flushed store gone");
  endtask

  task automatic t_full();
    set_block(1);
    for (int k = 0; k < 8; k++) do_ld(6'(16 + k), 16'(16'h0100 + 4 * k));
    expect_flag("R11 ld_full with 8 loads", ld_full, 1'b1);
    do_ld(6'd24, 16'h0200);
    set_block(0);
    for (int k = 0; k < 8; k++) begin
      expect_req("R11 R7 drain full load queue", 1, 0, 6'(16 + k), 16'(16'h0100 + 4 * k), 32'h0);
      tick();
    end
    expect_none("R11 load allocated while full was dropped");
    expect_flag("R11 ld_full after drain", ld_full, 1'b0);
    for (int k = 0; k < 8; k++) do_st(6'(25 + k));
    expect_flag("R11 st_full with 8 stores", st_full, 1'b1);
    do_st(6'd33);
    do_flush(6'd24);
    expect_flag("R10 flush empties uncommitted stores", st_full, 1'b0);
    do_sta(6'd33, 16'h0300); do_std(6'd33, 32'h333); do_cmt(6'd33);
    expect_none("R11 store allocated while full was dropped");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_store_combine();
    t_store_order();
    t_load_bypass();
    t_priority();
    t_flush();
    t_full();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule